// File: doc/BRIEF.md
# Packed Binary64 to Unsigned 32-bit Converter

This unit takes a vector of IEEE-754 double-precision values, up to eight lanes wide, and turns each active lane into an unsigned 32-bit integer. The results are packed side by side into the low half of the active vector length. Each result is rounded with a selectable mode. A value that cannot be held in 32 unsigned bits saturates to all-ones and raises an invalid flag.

The surrounding pipeline supplies the decoded controls with each operation. These are the vector length, a per-lane write mask with enable and merge/zero choice, the previous destination contents, a global and a per-operation rounding mode, the source kind (register or memory) with a broadcast bit, and a 4-bit reserved operand field. The unit has one register stage. The result and the flags for an operation appear on the cycle after `valid_i` is sampled high. The invalid and inexact flags are the OR over every active lane of that operation.

Top module: `pd2u_conv`

## Requirements
- R1: `vl_i` selects the lane count: 2'b00 gives 2 lanes, 2'b01 gives 4 and 2'b10 gives 8. Lane j converts `src_i[64j+63:64j]` into `dst_o[32j+31:32j]`. Every `dst_o` bit at or above 32 times the lane count is zero.
- R2: `glb_rm_i` and `emb_rm_i` encode the rounding mode as 2'b00 nearest-even, 2'b01 toward minus infinity, 2'b10 toward plus infinity and 2'b11 toward zero. A representable result that needed rounding sets `inx_o`.
- R3: A NaN, an infinity, or any value whose rounded result is below 0 or above 4294967295 gives 32'hFFFFFFFF in its lane and sets `inv_o`. Such a lane does not contribute to `inx_o`.
- R4: A negative value that rounds to zero gives 0 with only `inx_o` set. Both signed zeros give 0 with no flag. A subnormal gives 0 or 1 as its rounding mode dictates, with `inx_o` set, unless it rounds below zero (R3).
- R5: `emb_rm_i` is used only when `mem_i`=0, `vl_i`=2'b10 and `emb_en_i`=1. In every other case `glb_rm_i` is used.
- R6: When `mem_i`=1 and `bcast_i`=1, every active lane converts `src_i[63:0]`. For a register source (`mem_i`=0), `bcast_i` has no effect.
- R7: When `mask_en_i`=0, every lane within the length is written. When `mask_en_i`=1, a lane with a clear `mask_i[j]` bit takes `old_dst_i[32j+31:32j]` if `zero_i`=0 and takes 0 if `zero_i`=1.
- R8: `inv_o` and `inx_o` are the OR over active lanes only. Masked-off lanes and lanes beyond the length never set them.
- R9: When `rsv_i` is not 4'hF, or when `vl_i`=2'b11, the operation raises `illegal_o`. It then returns `old_dst_i` unchanged on `dst_o` with both flags clear.
- R10: The outputs for an operation appear one clock after `valid_i` is sampled high, and `valid_o` follows `valid_i` with the same delay. While `valid_i` is low, `dst_o` and the flags hold their values. After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| src_i | input | 512 | Source vector, 64 bits per lane |
| vl_i | input | 2 | Vector length select |
| mask_i | input | 8 | Per-lane write mask |
| mask_en_i | input | 1 | Masking enabled |
| zero_i | input | 1 | 1 = zero masked lanes, 0 = merge |
| old_dst_i | input | 512 | Previous destination contents |
| glb_rm_i | input | 2 | Global rounding mode |
| emb_rm_i | input | 2 | Per-operation rounding mode |
| emb_en_i | input | 1 | Per-operation rounding enable |
| mem_i | input | 1 | Source comes from memory |
| bcast_i | input | 1 | Broadcast element 0 (memory source) |
| rsv_i | input | 4 | Reserved operand field, must be all ones |
| valid_o | output | 1 | Result present |
| dst_o | output | 512 | Destination vector |
| inv_o | output | 1 | Invalid flag for the operation |
| inx_o | output | 1 | Inexact flag for the operation |
| illegal_o | output | 1 | Illegal encoding detected |

## Verification
The bench builds the unit with its default of eight lanes. This is the only setting where all three vector lengths are legal, so the per-operation rounding path, the 512-bit broadcast case and the clearing of every lane above 128 and 256 bits can all be reached. A real-number reference model in the bench computes each lane under all four rounding modes. It covers halfway ties, signed zeros, both subnormal signs, the edge at 4294967295 and inputs just beyond it. It also covers masked lanes whose values would otherwise raise a flag.

// File: rtl/pd2u_pkg.sv
package pd2u_pkg;
  localparam int unsigned ELEM_W = 64;
  localparam int unsigned RES_W  = 32;
  localparam int unsigned RSV_W  = 4;

  typedef enum logic [1:0] {
    RM_RNE = 2'b00,
    RM_RDN = 2'b01,
    RM_RUP = 2'b10,
    RM_RTZ = 2'b11
  } rm_e;

  typedef enum logic [1:0] {
    VL_128 = 2'b00,
    VL_256 = 2'b01,
    VL_512 = 2'b10,
    VL_BAD = 2'b11
  } vl_e;
endpackage

// File: rtl/pd2u_lane.sv
module pd2u_lane
  import pd2u_pkg::*;
(
  input  logic [ELEM_W-1:0] fp_i,
  input  logic [1:0]        rm_i,
  output logic [RES_W-1:0]  res_o,
  output logic              inv_o,
  output logic              inx_o
);
  localparam logic [10:0] EXP_HALF = 11'd1022; // value in [0.5,1)
  localparam logic [10:0] EXP_BIG  = 11'd1055; // value >= 2^32
  localparam logic [10:0] SH_BIAS  = 11'd1011; // shift = E + 12

  logic        sgn;
  logic [10:0] expo;
  logic [51:0] man;
  logic [52:0] sig;
  logic [5:0]  sh;
  logic [95:0] fx;
  logic [31:0] ipart;
  logic        rbit, sbit, inc, is_zero, is_spec, is_big, is_tiny;
  logic [32:0] mag;

  assign sgn  = fp_i[63];
  assign expo = fp_i[62:52];
  assign man  = fp_i[51:0];
  assign sig  = {1'b1, man};
  assign sh   = 6'(expo - SH_BIAS);
  assign fx   = {43'd0, sig} << sh;

  always_comb begin
    is_zero = (expo == '0) && (man == '0);
    is_spec = &expo;
    is_big  = expo >= EXP_BIG;
    is_tiny = (expo < EXP_HALF) && !is_zero;
    if (is_zero) begin
      ipart = '0; rbit = 1'b0; sbit = 1'b0;
    end else if (is_tiny) begin
      ipart = '0; rbit = 1'b0; sbit = 1'b1;
    end else begin
      ipart = fx[95:64]; rbit = fx[63]; sbit = |fx[62:0];
    end
    unique case (rm_i)
      RM_RNE:  inc = rbit & (sbit | ipart[0]);
      RM_RDN:  inc = sgn & (rbit | sbit);
      RM_RUP:  inc = ~sgn & (rbit | sbit);
      default: inc = 1'b0;
    endcase
    mag = {1'b0, ipart} + 33'(inc);
    if (is_spec || is_big || mag[32] || (sgn && mag != '0)) begin
      res_o = '1;
      inv_o = 1'b1;
      inx_o = 1'b0;
    end else begin
      res_o = sgn ? '0 : mag[31:0];
      inv_o = 1'b0;
      inx_o = rbit | sbit;
    end
  end
endmodule

// File: rtl/pd2u_ctl.sv
module pd2u_ctl
  import pd2u_pkg::*;
#(
  parameter int unsigned MAX_LANES = 8
) (
  input  logic [1:0]           vl_i,
  input  logic [RSV_W-1:0]     rsv_i,
  input  logic                 mem_i,
  input  logic                 bcast_i,
  input  logic                 emb_en_i,
  input  logic [1:0]           emb_rm_i,
  input  logic [1:0]           glb_rm_i,
  output logic [MAX_LANES-1:0] lane_en_o,
  output logic [1:0]           rm_o,
  output logic                 bcast_o,
  output logic                 illegal_o
);
  int unsigned nlanes;
  logic        use_emb;

  always_comb begin
    nlanes = 32'd2 << vl_i;
    for (int j = 0; j < MAX_LANES; j++) lane_en_o[j] = (j < int'(nlanes));
  end

  assign use_emb   = !mem_i && (vl_i == VL_512) && emb_en_i;
  assign rm_o      = use_emb ? emb_rm_i : glb_rm_i;
  assign bcast_o   = mem_i & bcast_i;
  assign illegal_o = (rsv_i != '1) || (vl_i == VL_BAD);
endmodule

// File: rtl/pd2u_conv.sv
module pd2u_conv
  import pd2u_pkg::*;
#(
  parameter int unsigned MAX_LANES = 8,
  localparam int unsigned SRC_W    = MAX_LANES * ELEM_W,
  localparam int unsigned RES_SPAN = MAX_LANES * RES_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [SRC_W-1:0]     src_i,
  input  logic [1:0]           vl_i,
  input  logic [MAX_LANES-1:0] mask_i,
  input  logic                 mask_en_i,
  input  logic                 zero_i,
  input  logic [SRC_W-1:0]     old_dst_i,
  input  logic [1:0]           glb_rm_i,
  input  logic [1:0]           emb_rm_i,
  input  logic                 emb_en_i,
  input  logic                 mem_i,
  input  logic                 bcast_i,
  input  logic [RSV_W-1:0]     rsv_i,
  output logic                 valid_o,
  output logic [SRC_W-1:0]     dst_o,
  output logic                 inv_o,
  output logic                 inx_o,
  output logic                 illegal_o
);
  logic [MAX_LANES-1:0] lane_en, lane_act, lane_inv, lane_inx;
  logic [1:0]           rm;
  logic                 bcast, illegal;
  logic [RES_SPAN-1:0]  packed_res;
  logic [SRC_W-1:0]     dst_nx;
  logic                 inv_nx, inx_nx;

  pd2u_ctl #(.MAX_LANES(MAX_LANES)) u_ctl (
    .vl_i      (vl_i),
    .rsv_i     (rsv_i),
    .mem_i     (mem_i),
    .bcast_i   (bcast_i),
    .emb_en_i  (emb_en_i),
    .emb_rm_i  (emb_rm_i),
    .glb_rm_i  (glb_rm_i),
    .lane_en_o (lane_en),
    .rm_o      (rm),
    .bcast_o   (bcast),
    .illegal_o (illegal)
  );

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    logic [ELEM_W-1:0] elem;
    logic [RES_W-1:0]  res;
    logic              inv, inx;

    assign elem = bcast ? src_i[ELEM_W-1:0] : src_i[j*ELEM_W +: ELEM_W];

    pd2u_lane u_lane (
      .fp_i  (elem),
      .rm_i  (rm),
      .res_o (res),
      .inv_o (inv),
      .inx_o (inx)
    );

    assign lane_act[j] = lane_en[j] & (~mask_en_i | mask_i[j]);
    assign lane_inv[j] = lane_act[j] & inv;
    assign lane_inx[j] = lane_act[j] & inx;

    always_comb begin
      if (lane_act[j])                           packed_res[j*RES_W +: RES_W] = res;
      else if (lane_en[j] && mask_en_i && !zero_i) packed_res[j*RES_W +: RES_W] = old_dst_i[j*RES_W +: RES_W];
      else                                       packed_res[j*RES_W +: RES_W] = '0;
    end
  end

  always_comb begin
    if (illegal) begin
      dst_nx = old_dst_i;
      inv_nx = 1'b0;
      inx_nx = 1'b0;
    end else begin
      dst_nx = {{(SRC_W-RES_SPAN){1'b0}}, packed_res};
      inv_nx = |lane_inv;
      inx_nx = |lane_inx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      dst_o     <= '0;
      inv_o     <= 1'b0;
      inx_o     <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        dst_o     <= dst_nx;
        inv_o     <= inv_nx;
        inx_o     <= inx_nx;
        illegal_o <= illegal;
      end
    end
  end
endmodule

// File: rtl/pd2u_conv_chk.sv
module pd2u_conv_chk
  import pd2u_pkg::*;
#(
  parameter int unsigned MAX_LANES = 8,
  localparam int unsigned SRC_W    = MAX_LANES * ELEM_W,
  localparam int unsigned RES_SPAN = MAX_LANES * RES_W
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic [1:0]           vl_i,
  input logic [MAX_LANES-1:0] mask_i,
  input logic                 mask_en_i,
  input logic                 zero_i,
  input logic [SRC_W-1:0]     old_dst_i,
  input logic [RSV_W-1:0]     rsv_i,
  input logic                 valid_o,
  input logic [SRC_W-1:0]     dst_o,
  input logic                 inv_o,
  input logic                 inx_o,
  input logic                 illegal_o
);
  logic any_sat;
  always_comb begin
    any_sat = 1'b0;
    for (int j = 0; j < MAX_LANES; j++)
      if (dst_o[j*RES_W +: RES_W] == '1) any_sat = 1'b1;
  end

  a_r10_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(dst_o) && $stable(inv_o) && $stable(inx_o)));

  a_r9_illegal_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rsv_i != '1) |=> (illegal_o && dst_o == $past(old_dst_i) && !inv_o && !inx_o));

  a_r1_upper_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !illegal_o) |-> (dst_o[SRC_W-1:RES_SPAN] == '0));

  a_r1_short_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rsv_i == '1 && vl_i == VL_128) |=> (dst_o[SRC_W-1:2*RES_W] == '0));

  a_r7_all_zeroed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rsv_i == '1 && vl_i != VL_BAD && mask_en_i && zero_i && mask_i == '0)
      |=> (dst_o == '0 && !inv_o && !inx_o));

  a_r3_saturated_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && inv_o) |-> any_sat);
endmodule

bind pd2u_conv pd2u_conv_chk #(.MAX_LANES(MAX_LANES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .vl_i      (vl_i),
  .mask_i    (mask_i),
  .mask_en_i (mask_en_i),
  .zero_i    (zero_i),
  .old_dst_i (old_dst_i),
  .rsv_i     (rsv_i),
  .valid_o   (valid_o),
  .dst_o     (dst_o),
  .inv_o     (inv_o),
  .inx_o     (inx_o),
  .illegal_o (illegal_o)
);

// File: tb/pd2u_conv_test.sv
`timescale 1ns/1ps
module pd2u_conv_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [511:0] src_i = '0;
  logic [1:0]   vl_i = 2'b10;
  logic [7:0]   mask_i = '0;
  logic         mask_en_i = 1'b0;
  logic         zero_i = 1'b0;
  logic [511:0] old_dst_i = '0;
  logic [1:0]   glb_rm_i = 2'b00;
  logic [1:0]   emb_rm_i = 2'b00;
  logic         emb_en_i = 1'b0;
  logic         mem_i = 1'b0;
  logic         bcast_i = 1'b0;
  logic [3:0]   rsv_i = 4'hF;
  logic         valid_o, inv_o, inx_o, illegal_o;
  logic [511:0] dst_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [511:0] e_dst;
  logic e_inv, e_inx, e_ill;

  always #2.5 clk = ~clk;

  pd2u_conv uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .src_i(src_i), .vl_i(vl_i),
    .mask_i(mask_i), .mask_en_i(mask_en_i), .zero_i(zero_i), .old_dst_i(old_dst_i),
    .glb_rm_i(glb_rm_i), .emb_rm_i(emb_rm_i), .emb_en_i(emb_en_i), .mem_i(mem_i),
    .bcast_i(bcast_i), .rsv_i(rsv_i), .valid_o(valid_o), .dst_o(dst_o),
    .inv_o(inv_o), .inx_o(inx_o), .illegal_o(illegal_o)
  );

  function automatic logic [63:0] d(input real x);
    return $realtobits(x);
  endfunction

  task automatic ref_cvt(input logic [63:0] b, input logic [1:0] rm,
                         output logic [31:0] r, output logic iv, output logic ix);
    real x, fl, fr, q;
    iv = 1'b0; ix = 1'b0; r = '0;
    if (b[62:52] == 11'h7FF) begin iv = 1'b1; r = '1; return; end
    x = $bitstoreal(b);
    if (x >= 8589934592.0 || x <= -8589934592.0) begin iv = 1'b1; r = '1; return; end
    fl = $floor(x);
    fr = x - fl;
    case (rm)
      2'b00: if (fr > 0.5) q = fl + 1.0;
             else if (fr < 0.5) q = fl;
             else q = ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
      2'b01: q = fl;
      2'b10: q = (fr != 0.0) ? fl + 1.0 : fl;
      default: q = (x < 0.0 && fr != 0.0) ? fl + 1.0 : fl;
    endcase
    ix = (fr != 0.0);
    if (q < 0.0 || q > 4294967295.0) begin iv = 1'b1; ix = 1'b0; r = '1; end
    else r = 32'(longint'(q));
  endtask

  task automatic model();
    int nl;
    logic [1:0] rm;
    logic [31:0] r;
    logic iv, ix;
    nl = 2 << vl_i;
    e_ill = (rsv_i != 4'hF) || (vl_i == 2'b11);
    rm = (!mem_i && vl_i == 2'b10 && emb_en_i) ? emb_rm_i : glb_rm_i;
    e_dst = '0; e_inv = 1'b0; e_inx = 1'b0;
    for (int j = 0; j < 8; j++) begin
      if (j < nl) begin
        if (!mask_en_i || mask_i[j]) begin
          ref_cvt((mem_i && bcast_i) ? src_i[63:0] : src_i[64*j +: 64], rm, r, iv, ix);
          e_dst[32*j +: 32] = r;
          e_inv |= iv;
          e_inx |= ix;
        end else if (!zero_i) begin
          e_dst[32*j +: 32] = old_dst_i[32*j +: 32];
        end
      end
    end
    if (e_ill) begin e_dst = old_dst_i; e_inv = 1'b0; e_inx = 1'b0; end
  endtask

  task automatic compare(input string tag, input logic e_val);
    n_vec++;
    if (dst_o !== e_dst || inv_o !== e_inv || inx_o !== e_inx ||
        illegal_o !== e_ill || valid_o !== e_val) begin
      n_bad++;
      $display("FAIL %s: dst=%h inv=%b inx=%b ill=%b vld=%b | exp dst=%h inv=%b inx=%b ill=%b vld=%b",
               tag, dst_o, inv_o, inx_o, illegal_o, valid_o, e_dst, e_inv, e_inx, e_ill, e_val);
    end
  endtask

  // inputs already set just after a falling edge
  task automatic apply(input string tag);
    model();
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    compare(tag, 1'b1);
  endtask

  task automatic set_lanes(input logic [63:0] a0, a1, a2, a3, a4, a5, a6, a7);
    src_i = {a7, a6, a5, a4, a3, a2, a1, a0};
  endtask

  task automatic defaults();
    vl_i = 2'b10; mask_en_i = 1'b0; zero_i = 1'b0; mask_i = '0; emb_en_i = 1'b0;
    mem_i = 1'b0; bcast_i = 1'b0; rsv_i = 4'hF; old_dst_i = {16{32'hA5A5_0F0F}};
  endtask

  task automatic t_reset();
    e_dst = '0; e_inv = 0; e_inx = 0; e_ill = 0;
    compare("R10 reset", 1'b0);
  endtask

  task automatic t_basic();
    defaults();
    set_lanes(d(1.5), d(2.5), d(3.7), d(0.0), d(4294967295.0), d(123456.75), d(-0.0), d(0.5));
    for (int m = 0; m < 4; m++) begin glb_rm_i = 2'(m); apply("R1 R2 basic"); end
    set_lanes(d(7.0), d(8.0), d(65536.0), d(1.0), d(0.0), d(3.0), d(42.0), d(100.0));
    glb_rm_i = 2'b00; apply("R2 exact no inexact");
  endtask

  task automatic t_negsub();
    defaults();
    set_lanes(d(-0.3), d(-0.7), 64'h0000_0000_0000_0001, 64'h8000_0000_0000_0001,
              d(-0.5), d(0.49999), 64'h000F_FFFF_FFFF_FFFF, d(-0.0));
    for (int m = 0; m < 4; m++) begin glb_rm_i = 2'(m); apply("R4 negative/subnormal"); end
    set_lanes(d(-0.3), d(-0.0), d(0.0), d(0.0), d(0.0), d(0.0), d(0.0), d(0.0));
    glb_rm_i = 2'b00; apply("R4 neg-to-zero inexact only");
  endtask

  task automatic t_invalid();
    defaults();
    set_lanes(64'h7FF8_0000_0000_0000, 64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000,
              d(4294967296.0), d(-1.0), d(4294967295.6), d(1.0e20), d(3.0));
    for (int m = 0; m < 4; m++) begin glb_rm_i = 2'(m); apply("R3 invalid saturate"); end
    set_lanes(d(4294967295.4), d(4294967294.5), d(2147483648.5), d(-0.9),
              d(0.0), d(0.0), d(0.0), d(0.0));
    for (int m = 0; m < 4; m++) begin glb_rm_i = 2'(m); apply("R3 range edge"); end
  endtask

  task automatic t_length();
    defaults();
    set_lanes(d(1.0), d(2.0), d(3.0), d(4.0), d(5.0), d(6.0), d(7.0), -64'd1);
    vl_i = 2'b00; apply("R1 128-bit");
    vl_i = 2'b01; apply("R1 256-bit");
    vl_i = 2'b00; mask_en_i = 1'b1; mask_i = 8'hFC; apply("R1 128-bit merge no spill");
  endtask

  task automatic t_rnd_sel();
    defaults();
    set_lanes(d(2.3), d(-0.2), d(5.5), d(9.9), d(1.1), d(0.0), d(6.5), d(7.5));
    glb_rm_i = 2'b11; emb_rm_i = 2'b10;
    emb_en_i = 1'b1; apply("R5 embedded used");
    emb_en_i = 1'b0; apply("R5 embedded disabled");
    emb_en_i = 1'b1; mem_i = 1'b1; apply("R5 memory source uses global");
    mem_i = 1'b0; vl_i = 2'b01; apply("R5 256-bit uses global");
  endtask

  task automatic t_bcast();
    defaults();
    set_lanes(d(7.5), d(1.0), d(2.0), d(3.0), d(4.0), d(5.0), d(6.0), d(8.0));
    glb_rm_i = 2'b00;
    mem_i = 1'b1; bcast_i = 1'b1; apply("R6 memory broadcast");
    vl_i = 2'b01; apply("R6 broadcast 256");
    vl_i = 2'b10; mem_i = 1'b0; apply("R6 register ignores broadcast");
    mem_i = 1'b1; bcast_i = 1'b0; apply("R6 memory no broadcast");
  endtask

  task automatic t_mask();
    defaults();
    set_lanes(d(11.0), d(12.0), d(13.0), d(14.0), d(15.0), d(16.0), d(17.0), d(18.0));
    mask_en_i = 1'b1; mask_i = 8'b1010_0110;
    zero_i = 1'b0; apply("R7 merge");
    zero_i = 1'b1; apply("R7 zero");
    mask_i = 8'h00; apply("R7 all zeroed");
    mask_en_i = 1'b0; apply("R7 mask disabled");
  endtask

  task automatic t_flags();
    defaults();
    set_lanes(64'h7FF8_0000_0000_0000, d(2.5), d(3.0), d(4.0), d(5.0), d(6.0), d(-3.0), d(8.0));
    mask_en_i = 1'b1; mask_i = 8'b1011_1100;
    zero_i = 1'b0; apply("R8 masked lanes raise nothing");
    zero_i = 1'b1; apply("R8 masked lanes raise nothing zeroing");
    vl_i = 2'b01; mask_en_i = 1'b0;
    set_lanes(d(1.0), d(2.0), d(3.0), d(4.0), 64'h7FF8_0000_0000_0000, d(0.5), d(0.0), d(0.0));
    apply("R8 lanes beyond length raise nothing");
    mask_en_i = 1'b1; mask_i = 8'hFF; vl_i = 2'b10; apply("R8 unmasked flags");
  endtask

  task automatic t_illegal();
    defaults();
    set_lanes(d(1.5), d(2.0), d(3.0), d(4.0), d(5.0), d(6.0), d(7.0), 64'h7FF0_0000_0000_0000);
    rsv_i = 4'hE; apply("R9 reserved field");
    rsv_i = 4'h0; apply("R9 reserved zero");
    rsv_i = 4'hF; vl_i = 2'b11; apply("R9 bad length");
  endtask

  task automatic t_hold();
    defaults();
    set_lanes(d(21.0), d(22.5), d(0.0), d(0.0), d(0.0), d(0.0), d(0.0), d(0.0));
    apply("R10 latency");
    src_i = '1; rsv_i = 4'h0;
    @(negedge clk); @(negedge clk);
    compare("R10 hold while idle", 1'b0);
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: run did not complete (actual timeout, expected finish)");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_negsub();
    t_invalid();
    t_length();
    t_rnd_sel();
    t_bcast();
    t_mask();
    t_flags();
    t_illegal();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule